// File: doc/BRIEF.md
# PPS-Latched Time Base Counter

This block keeps the absolute sense of time for a device: a 64-bit counter that advances once per sample clock and drives the time output that timed command queues and the stream controller compare against. Several devices fed by the same pulse-per-second signal share one timeline because a new time value never takes effect when software writes it. It waits as a pending value and is loaded on the next rising edge of the synchronized pulse.

Every pulse edge also captures the counter into a last-pulse register. Software polls that register until it changes, which shows that a fresh pulse has just passed. It then writes the load value (usually zero) and arms it. On the next shared pulse, every device jumps to the same value in the same cycle. A small word-wide register port gives access to the load value, the arm flag, the live time and the last-pulse time. The 64-bit values are read as two words, and reading the low word freezes the matching high word.

Top module: `tbase_timekeeper`

## Requirements
- R1: While `rst` is high (synchronous, active high), `time_now`, the last-pulse time, the load value, the arm flag, `load_pending` and `rd_data` are all zero.
- R2: In a cycle with no armed pulse edge, `time_now` increases by exactly one, wrapping at 2^64.
- R3: `pps_in` passes through a two-flop synchronizer, and one internal edge event is made per low-to-high transition. A rise driven before clock edge k acts at edge k+2. A level held high gives no further events, and a falling transition gives none.
- R4: At a pulse edge with the arm flag set, `time_now` takes the load value (word 0 = bits 31:0, word 1 = bits 63:32) in place of incrementing. At an unarmed edge it keeps incrementing.
- R5: Writing word 2 sets the arm flag to `wr_data[0]`, so writing 0 cancels a pending load. The flag clears itself when the load happens. It appears on `load_pending` and in bit 0 of a word 2 read, with the other bits zero.
- R6: At every pulse edge, the counter value held just before that edge's update is captured as the last-pulse time. It is read as word 5 (low) and word 6 (high), and it holds between edges.
- R7: Reading word 3 returns the live time bits 31:0 and freezes bits 63:32. Word 4 returns the frozen half. Words 5 and 6 pair the same way for the last-pulse time, so each 64-bit value is read coherently across a carry.
- R8: `rd_data` updates on the clock edge that samples `rd_en` and is valid from the next cycle. It holds its value when `rd_en` is low. Word 7 reads as zero, and writes to words 3 to 7 have no effect.
- R9: The load words read back the values written to them.
- R10: If an arm write lands in the same cycle as a pulse edge, that edge acts on the previous flag state, and the flag afterwards equals the written bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word select |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read word select |
| rd_data | output | 32 | Registered read data |
| time_now | output | 64 | Live time count |
| load_pending | output | 1 | Arm flag: a load waits for the next pulse edge |

## Verification
A rise on `pps_in` reaches the counter and the last-pulse register at the third clock edge after it is driven. `time_now` and `load_pending` reflect a write or a pulse after one clock edge, and `rd_data` is due one edge after the read strobe. The bench drives inputs on the falling edge and advances a reference model on each rising edge using the same latencies. It compares all outputs on the following falling edge, so each result is sampled in the cycle it is due. Directed checks pin down the exact edge of a load, and they check that a snapshot stays coherent across a low-word carry.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_LOAD_LO = 3'd0,
        REG_LOAD_HI = 3'd1,
        REG_CTRL    = 3'd2,
        REG_NOW_LO  = 3'd3,
        REG_NOW_HI  = 3'd4,
        REG_PPS_LO  = 3'd5,
        REG_PPS_HI  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/tbase_pps_edge.sv
module tbase_pps_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_async,
    output logic pps_rise
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-1:0], pps_async};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pps_rise = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

    // one event per transition
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
        pps_rise |=> !pps_rise);
endmodule

// File: rtl/tbase_time_core.sv
module tbase_time_core #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_rise,
    input  logic [TIME_W-1:0] load_val,
    input  logic              arm_wr,
    input  logic              arm_val,
    output logic [TIME_W-1:0] time_out,
    output logic [TIME_W-1:0] last_pps,
    output logic              armed
);
    typedef struct packed {
        logic [TIME_W-1:0] count;
        logic [TIME_W-1:0] latch;
        logic              arm;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.count = st_q.count + 1'b1;
        if (pps_rise) begin
            st_d.latch = st_q.count;
            if (st_q.arm) begin
                st_d.count = load_val;
                st_d.arm   = 1'b0;
            end
        end
        if (arm_wr) st_d.arm = arm_val;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign time_out = st_q.count;
    assign last_pps = st_q.latch;
    assign armed    = st_q.arm;

    assert_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !(pps_rise && armed) |=> time_out == $past(time_out) + 1'b1);
    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        (pps_rise && armed) |=> time_out == $past(load_val));
    assert_arm_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (pps_rise && armed && !arm_wr) |=> !armed);
    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        pps_rise |=> last_pps == $past(time_out));
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !pps_rise |=> $stable(last_pps));
    assert_arm_write_R10: assert property (@(posedge clk) disable iff (rst)
        arm_wr |=> armed == $past(arm_val));
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
    import tbase_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [BUS_W-1:0]     wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    input  logic [2*BUS_W-1:0]   time_in,
    input  logic [2*BUS_W-1:0]   pps_in_time,
    input  logic                 armed,
    output logic [2*BUS_W-1:0]   load_val,
    output logic                 arm_wr,
    output logic                 arm_val,
    output logic [BUS_W-1:0]     rd_data
);
    typedef struct packed {
        logic [2*BUS_W-1:0] load;
        logic [BUS_W-1:0]   now_hi;
        logic [BUS_W-1:0]   pps_hi;
        logic [BUS_W-1:0]   rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_LOAD_LO: st_d.load[BUS_W-1:0]       = wr_data;
                REG_LOAD_HI: st_d.load[2*BUS_W-1:BUS_W] = wr_data;
                default: ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = '0;
            case (reg_addr_e'(rd_addr))
                REG_LOAD_LO: st_d.rdata = st_q.load[BUS_W-1:0];
                REG_LOAD_HI: st_d.rdata = st_q.load[2*BUS_W-1:BUS_W];
                REG_CTRL:    st_d.rdata[0] = armed;
                REG_NOW_LO: begin
                    st_d.rdata  = time_in[BUS_W-1:0];
                    st_d.now_hi = time_in[2*BUS_W-1:BUS_W];
                end
                REG_NOW_HI:  st_d.rdata = st_q.now_hi;
                REG_PPS_LO: begin
                    st_d.rdata  = pps_in_time[BUS_W-1:0];
                    st_d.pps_hi = pps_in_time[2*BUS_W-1:BUS_W];
                end
                REG_PPS_HI:  st_d.rdata = st_q.pps_hi;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign load_val = st_q.load;
    assign arm_wr   = wr_en && (wr_addr == REG_CTRL);
    assign arm_val  = wr_data[0];
    assign rd_data  = st_q.rdata;

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    assert_now_lo_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == REG_NOW_LO) |=> rd_data == $past(time_in[BUS_W-1:0]));
    assert_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == REG_CTRL) |=> rd_data == {{(BUS_W-1){1'b0}}, $past(armed)});
endmodule

// File: rtl/tbase_timekeeper.sv
module tbase_timekeeper
    import tbase_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pps_in,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [BUS_W-1:0]    wr_data,
    input  logic                rd_en,
    input  logic [2:0]          rd_addr,
    output logic [BUS_W-1:0]    rd_data,
    output logic [2*BUS_W-1:0]  time_now,
    output logic                load_pending
);
    localparam int TIME_W = 2 * BUS_W;

    logic              pps_rise;
    logic [TIME_W-1:0] load_val;
    logic [TIME_W-1:0] last_pps;
    logic              arm_wr;
    logic              arm_val;

    tbase_pps_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pps_async(pps_in), .pps_rise(pps_rise)
    );

    tbase_time_core #(.TIME_W(TIME_W)) u_core (
        .clk(clk), .rst(rst), .pps_rise(pps_rise), .load_val(load_val),
        .arm_wr(arm_wr), .arm_val(arm_val), .time_out(time_now),
        .last_pps(last_pps), .armed(load_pending)
    );

    tbase_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .time_in(time_now), .pps_in_time(last_pps), .armed(load_pending),
        .load_val(load_val), .arm_wr(arm_wr), .arm_val(arm_val),
        .rd_data(rd_data)
    );

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (time_now == '0 && !load_pending && rd_data == '0));
endmodule

// File: tb/tb_tbase_timekeeper.sv
module tb_tbase_timekeeper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pps_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] time_now;
    logic        load_pending;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tbase_timekeeper dut (
        .clk(clk), .rst(rst), .pps_in(pps_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .time_now(time_now),
        .load_pending(load_pending)
    );

    // reference model built from the requirements
    logic [2:0]  m_sync;
    logic [63:0] m_time, m_last, m_load;
    logic [31:0] m_nhi, m_phi, m_rd;
    logic        m_armed, m_edge;
    string       m_ttag, m_rtag;

    always @(posedge clk) begin
        if (rst) begin
            m_sync <= '0; m_time <= '0; m_last <= '0; m_load <= '0;
            m_nhi <= '0; m_phi <= '0; m_rd <= '0; m_armed <= 1'b0;
            m_ttag <= "R1"; m_rtag <= "R1";
        end else begin
            m_sync <= {m_sync[1:0], pps_in};
            m_edge  = m_sync[1] & ~m_sync[2];
            m_time <= m_time + 64'd1;
            m_ttag <= "R2";
            if (m_edge) begin
                m_last <= m_time;
                if (m_armed) begin
                    m_time  <= m_load;
                    m_armed <= 1'b0;
                    m_ttag  <= "R4";
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_load[31:0]  <= wr_data;
                    3'd1: m_load[63:32] <= wr_data;
                    3'd2: m_armed       <= wr_data[0];
                    default: ;
                endcase
            end
            if (rd_en) begin
                case (rd_addr)
                    3'd0: begin m_rd <= m_load[31:0];  m_rtag <= "R9"; end
                    3'd1: begin m_rd <= m_load[63:32]; m_rtag <= "R9"; end
                    3'd2: begin m_rd <= {31'd0, m_armed}; m_rtag <= "R5"; end
                    3'd3: begin m_rd <= m_time[31:0]; m_nhi <= m_time[63:32]; m_rtag <= "R7"; end
                    3'd4: begin m_rd <= m_nhi; m_rtag <= "R7"; end
                    3'd5: begin m_rd <= m_last[31:0]; m_phi <= m_last[63:32]; m_rtag <= "R6"; end
                    3'd6: begin m_rd <= m_phi; m_rtag <= "R6"; end
                    default: begin m_rd <= '0; m_rtag <= "R8"; end
                endcase
            end
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(m_ttag, time_now, m_time);
            check("R5", {63'd0, load_pending}, {63'd0, m_armed});
            check(m_rtag, {32'd0, rd_data}, {32'd0, m_rd});
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] seen;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        idle(3);
        check("R1", time_now, 64'd0);
        check("R1", {32'd0, rd_data}, 64'd0);
        @(negedge clk); rst = 1'b0;
        idle(5);
        check("R2", time_now, 64'd5);

        // R9 load words, R4 armed load across carry region
        wr(3'd0, 32'hFFFF_FFF0);
        wr(3'd1, 32'h0000_0001);
        rd(3'd0); check("R9", {32'd0, rd_data}, 64'h0000_0000_FFFF_FFF0);
        wr(3'd2, 32'h1);
        check("R5", {63'd0, load_pending}, 64'd1);
        @(negedge clk); pps_in = 1'b1;
        idle(2);
        check("R3", {63'd0, load_pending}, 64'd1);
        idle(1);
        check("R4", time_now, 64'h0000_0001_FFFF_FFF0);
        check("R5", {63'd0, load_pending}, 64'd0);
        // R7 coherent snapshot across low-word carry
        rd(3'd3);
        idle(20);
        check("R7", {32'd0, time_now[63:32]}, 64'd2);
        rd(3'd4); check("R7", {32'd0, rd_data}, 64'd1);
        // R3 held level: no new edge, R6 capture holds
        rd(3'd5); seen = {32'd0, rd_data};
        idle(10);
        rd(3'd5); check("R6", {32'd0, rd_data}, seen);
        @(negedge clk); pps_in = 1'b0;
        // R5 cancel
        wr(3'd2, 32'h1); wr(3'd2, 32'h0);
        @(negedge clk); pps_in = 1'b1;
        idle(4);
        check("R5", {63'd0, load_pending}, 64'd0);
        @(negedge clk); pps_in = 1'b0;
        // R8 unmapped read and ignored write
        wr(3'd7, 32'hDEAD_BEEF);
        rd(3'd7); check("R8", {32'd0, rd_data}, 64'd0);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 29) == 0) pps_in = ~pps_in;
            wr_en   = ($urandom_range(0, 5) == 0);
            wr_addr = 3'($urandom_range(0, 7));
            wr_data = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
            rd_en   = ($urandom_range(0, 2) == 0);
            rd_addr = 3'($urandom_range(0, 7));
        end
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        idle(4);
        summary();
    end
endmodule